// File: doc/BRIEF.md
# Protection and Attribute Shadow Register Bank

This block holds a local replica of the memory protection registers and the memory attribute registers. Address checkers sit far from the central CSR unit, so they read this replica instead. The replica never changes by itself. It follows the central unit by watching that unit's CSR write strobe, CSR number and write data, and it applies each write under the same rules as the central unit.

There are two banks of `ENTRIES` entries each: a protection bank and an attribute bank. Every entry drives three outputs:

- its configuration byte;
- its address register, which holds the physical address shifted right by two;
- a region mask whose low ones give the log2 of the region size.

The mask depends on the address register alone, so it is computed when the address is written. This keeps the trailing-ones logic out of the checkers' path. Regions are never smaller than 4 KB.

In the attribute bank, the two reserved configuration bits are kept. Bit 6 is the atomic flag and bit 5 is the cacheable flag. Attribute entries start from reset values that the platform supplies as parameters. Protection entries reset to zero.

Top module: `pmp_shadow_regs`

## Requirements
- R1: After reset every protection entry has configuration 0 and address 0. Attribute entry k has configuration `PMA_CFG_INIT[8k+7:8k]` and address `PMA_ADDR_INIT[AW*k+AW-1:AW*k]`, where AW = PADDR_W-2.
- R2: A write to CSR `CFG_BASE + 2*j` loads byte n of the data (bits 8n+7:8n) into entry 8j+n, for all eight bytes at once. Writes to odd CSR numbers in that range change nothing.
- R3: A write to CSR `ADDR_BASE + k` loads data bits AW-1:0 into the address register of entry k.
- R4: Configuration byte layout: bit 7 lock, bits 4:3 mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 2 execute, bit 1 write, bit 0 read. In the protection bank bits 6:5 always read 0. In the attribute bank bit 6 (atomic) and bit 5 (cacheable) keep the written value.
- R5: When an entry's mode is not 3, its mask is 12'hfff, with all higher bits 0.
- R6: When the mode is 3 and the address register has x trailing ones, the mask has min(PADDR_W, max(12, x+3)) low ones and zeros above. An address of 0xF000 gives 0xfff. An address of 0xBFFF gives 0x1ffff.
- R7: The new address and mask of an entry appear together, right after the clock edge that takes the write.
- R8: While an entry's lock bit is set, writes to its configuration byte and to its address register are ignored. The other bytes of the same configuration CSR still update.
- R9: A write to the address of entry k is ignored when entry k+1 is locked in mode 1. It is accepted when entry k+1 is locked in any other mode.
- R10: No output changes in a cycle where the write strobe is low, or where the CSR number matches no register of either bank.
- R11: The two banks use separate CSR numbers (`PMP_*_BASE`, `PMA_*_BASE`). A write to one bank never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wen | input | 1 | CSR write strobe seen at the central CSR unit |
| csr_waddr | input | 12 | CSR number of the write |
| csr_wdata | input | 64 | CSR write data |
| pmp_cfg_o | output | 8*ENTRIES | Protection configuration bytes, entry k at bits 8k+7:8k |
| pmp_addr_o | output | (PADDR_W-2)*ENTRIES | Protection address registers |
| pmp_mask_o | output | PADDR_W*ENTRIES | Protection region masks |
| pma_cfg_o | output | 8*ENTRIES | Attribute configuration bytes |
| pma_addr_o | output | (PADDR_W-2)*ENTRIES | Attribute address registers |
| pma_mask_o | output | PADDR_W*ENTRIES | Attribute region masks |

## Verification
The mask is driven with four kinds of address: one with no trailing ones (shows the 4 KB clamp), one with fourteen trailing ones (shows the log2 count above the clamp), an all-ones address (shows saturation at the mask width), and a power-of-two address written while the mode is off (shows that the mode selects the mask).

Configuration writes use three byte patterns:
- bytes with the reserved bits set, which separates the protection bank's clearing of those bits from the attribute bank's keeping of them;
- lock patterns that pair a top-of-range mode with a power-of-two mode, which tells the neighbour guard apart from a plain lock;
- a full rewrite of a CSR that holds locked entries, which shows that only the locked bytes hold.

Odd CSR numbers, unmapped CSR numbers, writes with the strobe low and writes to the other bank's CSRs confirm that nothing outside the addressed entry moves.

// File: rtl/pmp_shadow_regs.sv
module pmp_shadow_regs #(
  parameter int          ENTRIES       = 16,
  parameter int          PADDR_W       = 48,
  parameter logic [11:0] PMP_CFG_BASE  = 12'h3A0,
  parameter logic [11:0] PMP_ADDR_BASE = 12'h3B0,
  parameter logic [11:0] PMA_CFG_BASE  = 12'h7C0,
  parameter logic [11:0] PMA_ADDR_BASE = 12'h7D0,
  parameter logic [8*ENTRIES-1:0]           PMA_CFG_INIT  = '0,
  parameter logic [(PADDR_W-2)*ENTRIES-1:0] PMA_ADDR_INIT = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             csr_wen,
  input  logic [11:0]                      csr_waddr,
  input  logic [63:0]                      csr_wdata,
  output logic [8*ENTRIES-1:0]             pmp_cfg_o,
  output logic [(PADDR_W-2)*ENTRIES-1:0]   pmp_addr_o,
  output logic [PADDR_W*ENTRIES-1:0]       pmp_mask_o,
  output logic [8*ENTRIES-1:0]             pma_cfg_o,
  output logic [(PADDR_W-2)*ENTRIES-1:0]   pma_addr_o,
  output logic [PADDR_W*ENTRIES-1:0]       pma_mask_o
);
  localparam int AW = PADDR_W - 2;
  localparam logic [PADDR_W-1:0] MIN_SPAN = PADDR_W'(12'hfff);

  function automatic logic [PADDR_W-1:0] span_of(input logic [AW-1:0] a);
    logic [AW+2:0] v;
    v = {a, 3'b111};
    v = v & ~(v + (AW+3)'(1));
    return v[PADDR_W-1:0] | MIN_SPAN;
  endfunction

  logic [7:0] cfg_w [2][ENTRIES];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
      localparam logic [11:0] CFG_CSR = (b == 0 ? PMP_CFG_BASE : PMA_CFG_BASE) + 12'(2 * (k / 8));
      localparam logic [11:0] ADR_CSR = (b == 0 ? PMP_ADDR_BASE : PMA_ADDR_BASE) + 12'(k);
      localparam int          LANE    = k % 8;
      localparam logic [7:0]  KEEP    = (b == 0) ? 8'h9F : 8'hFF;
      localparam logic [7:0]  CFG_RST = (b == 0) ? 8'h00 : PMA_CFG_INIT[8*k +: 8];
      localparam logic [AW-1:0] ADR_RST = (b == 0) ? '0 : PMA_ADDR_INIT[AW*k +: AW];

      logic [7:0]         cfg_q;
      logic [AW-1:0]      addr_q;
      logic [PADDR_W-1:0] span_q;
      logic               guard;
      logic [PADDR_W-1:0] mask;

      if (k < ENTRIES - 1) begin : g_nb
        assign guard = cfg_w[b][k+1][7] && (cfg_w[b][k+1][4:3] == 2'b01);
      end else begin : g_last
        assign guard = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q  <= CFG_RST;
          addr_q <= ADR_RST;
          span_q <= span_of(ADR_RST);
        end else if (csr_wen && !cfg_q[7]) begin
          if (csr_waddr == CFG_CSR)
            cfg_q <= csr_wdata[8*LANE +: 8] & KEEP;
          if (csr_waddr == ADR_CSR && !guard) begin
            addr_q <= csr_wdata[AW-1:0];
            span_q <= span_of(csr_wdata[AW-1:0]);
          end
        end
      end

      assign cfg_w[b][k] = cfg_q;
      assign mask = (cfg_q[4:3] == 2'b11) ? span_q : MIN_SPAN;

      if (b == 0) begin : g_p
        assign pmp_cfg_o[8*k +: 8]            = cfg_q;
        assign pmp_addr_o[AW*k +: AW]         = addr_q;
        assign pmp_mask_o[PADDR_W*k +: PADDR_W] = mask;
      end else begin : g_a
        assign pma_cfg_o[8*k +: 8]            = cfg_q;
        assign pma_addr_o[AW*k +: AW]         = addr_q;
        assign pma_mask_o[PADDR_W*k +: PADDR_W] = mask;
      end
    end
  end
endmodule

module pmp_shadow_regs_chk #(
  parameter int          ENTRIES       = 16,
  parameter int          PADDR_W       = 48,
  parameter logic [11:0] PMP_ADDR_BASE = 12'h3B0
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           csr_wen,
  input logic [11:0]                    csr_waddr,
  input logic [63:0]                    csr_wdata,
  input logic [8*ENTRIES-1:0]           pmp_cfg_o,
  input logic [(PADDR_W-2)*ENTRIES-1:0] pmp_addr_o,
  input logic [PADDR_W*ENTRIES-1:0]     pmp_mask_o,
  input logic [8*ENTRIES-1:0]           pma_cfg_o,
  input logic [(PADDR_W-2)*ENTRIES-1:0] pma_addr_o,
  input logic [PADDR_W*ENTRIES-1:0]     pma_mask_o
);
  localparam int AW = PADDR_W - 2;

  logic tor_lock1;
  assign tor_lock1 = pmp_cfg_o[15] && (pmp_cfg_o[12:11] == 2'b01);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wen |=> $stable(pmp_cfg_o) && $stable(pmp_addr_o) && $stable(pmp_mask_o)
              && $stable(pma_cfg_o) && $stable(pma_addr_o) && $stable(pma_mask_o));

  p_resv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pmp_cfg_o & {ENTRIES{8'h60}}) == '0);

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pmp_cfg_o[7] |=> $stable(pmp_cfg_o[7:0]) && $stable(pmp_addr_o[AW-1:0]));

  p_addr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wen && csr_waddr == PMP_ADDR_BASE && !pmp_cfg_o[7] && !tor_lock1
    |=> pmp_addr_o[AW-1:0] == $past(csr_wdata[AW-1:0]));

  p_tor_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wen && csr_waddr == PMP_ADDR_BASE && tor_lock1 |=> $stable(pmp_addr_o[AW-1:0]));

  for (genvar k = 0; k < ENTRIES; k++) begin : g_m
    logic [PADDR_W-1:0] pm, am;
    assign pm = pmp_mask_o[PADDR_W*k +: PADDR_W];
    assign am = pma_mask_o[PADDR_W*k +: PADDR_W];
    p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (&pm[11:0]) && ((pm & (pm + PADDR_W'(1))) == '0)
      && (&am[11:0]) && ((am & (am + PADDR_W'(1))) == '0));
  end
endmodule

bind pmp_shadow_regs pmp_shadow_regs_chk #(
  .ENTRIES(ENTRIES), .PADDR_W(PADDR_W), .PMP_ADDR_BASE(PMP_ADDR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wen(csr_wen), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
  .pmp_cfg_o(pmp_cfg_o), .pmp_addr_o(pmp_addr_o), .pmp_mask_o(pmp_mask_o),
  .pma_cfg_o(pma_cfg_o), .pma_addr_o(pma_addr_o), .pma_mask_o(pma_mask_o)
);

// File: tb/pmp_shadow_regs_test.sv
`timescale 1ns/1ps
module pmp_shadow_regs_test;
  localparam int N  = 16;
  localparam int PW = 48;
  localparam int AW = PW - 2;
  localparam logic [8*N-1:0]  CINIT = {{(N-2){8'h00}}, 8'h8F, 8'h7B};
  localparam logic [AW*N-1:0] AINIT = {{(N-2)*AW{1'b0}}, AW'(46'h1000), AW'(46'h3FF)};

  logic clk = 1'b0, rst_n = 1'b0, csr_wen = 1'b0;
  logic [11:0] csr_waddr = '0;
  logic [63:0] csr_wdata = '0;
  logic [8*N-1:0]  pmp_cfg_o, pma_cfg_o;
  logic [AW*N-1:0] pmp_addr_o, pma_addr_o;
  logic [PW*N-1:0] pmp_mask_o, pma_mask_o;

  always #4 clk = ~clk;

  pmp_shadow_regs #(.ENTRIES(N), .PADDR_W(PW), .PMA_CFG_INIT(CINIT), .PMA_ADDR_INIT(AINIT)) uut (
    .clk(clk), .rst_n(rst_n), .csr_wen(csr_wen), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
    .pmp_cfg_o(pmp_cfg_o), .pmp_addr_o(pmp_addr_o), .pmp_mask_o(pmp_mask_o),
    .pma_cfg_o(pma_cfg_o), .pma_addr_o(pma_addr_o), .pma_mask_o(pma_mask_o));

  typedef struct {
    int bank; int idx; logic [7:0] cfg; logic [AW-1:0] addr; logic [PW-1:0] mask; string tag;
  } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic [PW-1:0] ref_mask(input logic [7:0] c, input logic [AW-1:0] a);
    int x = 0, n;
    logic [PW-1:0] m = '0;
    if (c[4:3] != 2'b11) return PW'(12'hfff);
    while (x < AW && a[x]) x++;
    n = (x + 3 < 12) ? 12 : x + 3;
    if (n > PW) n = PW;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic expect_ent(input int bank, input int idx, input logic [7:0] c,
                            input logic [AW-1:0] a, input string tag);
    item_t it;
    it.bank = bank; it.idx = idx; it.cfg = c; it.addr = a; it.mask = ref_mask(c, a); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input bit en = 1'b1);
    @(negedge clk);
    csr_wen = en; csr_waddr = a; csr_wdata = d;
    @(negedge clk);
    csr_wen = 1'b0;
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        if (it.bank == 0) begin
          cmp(it.tag, $sformatf("pmp%0d cfg", it.idx), 64'(pmp_cfg_o[8*it.idx +: 8]), 64'(it.cfg));
          cmp(it.tag, $sformatf("pmp%0d addr", it.idx), 64'(pmp_addr_o[AW*it.idx +: AW]), 64'(it.addr));
          cmp(it.tag, $sformatf("pmp%0d mask", it.idx), 64'(pmp_mask_o[PW*it.idx +: PW]), 64'(it.mask));
        end else begin
          cmp(it.tag, $sformatf("pma%0d cfg", it.idx), 64'(pma_cfg_o[8*it.idx +: 8]), 64'(it.cfg));
          cmp(it.tag, $sformatf("pma%0d addr", it.idx), 64'(pma_addr_o[AW*it.idx +: AW]), 64'(it.addr));
          cmp(it.tag, $sformatf("pma%0d mask", it.idx), 64'(pma_mask_o[PW*it.idx +: PW]), 64'(it.mask));
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [AW-1:0] ONES = '1;

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    expect_ent(0, 0, 8'h00, 0, "R1");
    expect_ent(0, 5, 8'h00, 0, "R1");
    expect_ent(0, 15, 8'h00, 0, "R1");
    expect_ent(1, 0, 8'h7B, 46'h3FF, "R1_R6");
    expect_ent(1, 1, 8'h8F, 46'h1000, "R1");
    expect_ent(1, 3, 8'h00, 0, "R1");
    // R3 address load, R5 mask with mode off
    wr(12'h3B0, 64'hF000);
    expect_ent(0, 0, 8'h00, 46'hF000, "R3_R5");
    // R2 all bytes of cfg CSR 0, R4 reserved bits dropped, R6 clamp
    wr(12'h3A0, 64'h1800_0000_0000_0B7F);
    expect_ent(0, 0, 8'h1F, 46'hF000, "R4_R6");
    expect_ent(0, 1, 8'h0B, 0, "R2");
    expect_ent(0, 7, 8'h18, 0, "R2");
    expect_ent(0, 3, 8'h00, 0, "R2");
    // R6 / R7 mask above clamp, visible with the address
    wr(12'h3B0, 64'hBFFF);
    expect_ent(0, 0, 8'h1F, 46'hBFFF, "R6_R7");
    // R6 saturation
    wr(12'h3B0, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_ent(0, 0, 8'h1F, ONES, "R6");
    // R2 second cfg CSR: entry8 locked NAPOT, entry11 locked TOR
    wr(12'h3A2, 64'h0000_0000_8800_0098);
    expect_ent(0, 8, 8'h98, 0, "R2");
    expect_ent(0, 9, 8'h00, 0, "R2");
    expect_ent(0, 11, 8'h88, 0, "R2");
    // R9 guard by locked TOR neighbour; not by locked NAPOT neighbour
    wr(12'h3BA, 64'h77);
    expect_ent(0, 10, 8'h00, 0, "R9");
    wr(12'h3B7, 64'h123);
    expect_ent(0, 7, 8'h18, 46'h123, "R9");
    // R8 locked entries hold, neighbours in same CSR update
    wr(12'h3B8, 64'h55);
    expect_ent(0, 8, 8'h98, 0, "R8");
    wr(12'h3A2, 64'h0909_0909_0909_0909);
    expect_ent(0, 8, 8'h98, 0, "R8");
    expect_ent(0, 9, 8'h09, 0, "R8");
    expect_ent(0, 11, 8'h88, 0, "R8");
    expect_ent(0, 15, 8'h09, 0, "R8");
    // R2 odd cfg number ignored
    wr(12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_ent(0, 0, 8'h1F, ONES, "R2");
    expect_ent(0, 1, 8'h0B, 0, "R2");
    // R10 strobe low, unmapped number
    wr(12'h3B1, 64'h5555, 1'b0);
    expect_ent(0, 1, 8'h0B, 0, "R10");
    wr(12'h3C0, 64'h1234);
    expect_ent(0, 0, 8'h1F, ONES, "R10");
    // R9 / R11 attribute bank: entry1 locked TOR guards entry0 address
    wr(12'h7D0, 64'hAA);
    expect_ent(1, 0, 8'h7B, 46'h3FF, "R9_R11");
    // R4 attribute reserved bits kept, R5 mode off, R8 locked entry1, R11 other bank
    wr(12'h7C0, 64'h65);
    expect_ent(1, 0, 8'h65, 46'h3FF, "R4_R5");
    expect_ent(1, 1, 8'h8F, 46'h1000, "R8");
    expect_ent(0, 0, 8'h1F, ONES, "R11");
    wr(12'h7D2, 64'h1FFF);
    expect_ent(1, 2, 8'h00, 46'h1FFF, "R3_R5");
    expect_ent(0, 2, 8'h00, 0, "R11");
    wr(12'h7C0, 64'h18_0065);
    expect_ent(1, 2, 8'h18, 46'h1FFF, "R6");
    expect_ent(1, 0, 8'h65, 46'h3FF, "R2");
    expect_ent(0, 2, 8'h00, 0, "R11");
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule